// File: doc/BRIEF.md
# Event Wait and Wake-Up Controller

This block decides when a small controller core runs and when its clock is held. It watches eight event lines and carries out two kinds of wait command, each naming one event line. One waits for the line to read low and the other waits for it to read high. While the condition is not met, the core clock enable is held low. If the condition is already true when the command arrives, the wait ends in one clock and the clock enable never drops.

A sleep command carries a mask that arms any of four separate wake sources. The clock stays stopped until an armed source goes high. Execution then resumes at a handler address rather than at the next instruction. The same path runs after reset, once the core reports that it is ready. The handler address is a table base plus a small index: 0 for reset, and 1 to 4 for wake sources 0 to 3.

Every resume follows the same order. The clock enable rises first, and the resume strobe comes one clock later. The core therefore always has a clean clock edge before it acts on the strobe.

Top module: `evt_wake_ctrl`

## Requirements
- R1: Event and wake inputs pass through a two-stage synchronizer. A change that meets a waiting condition raises `clk_en_o` at the third rising edge after the change, and `resume_o` at the fourth.
- R2: Command encodings on `cmd_op_i` are 2'b01 for wait-until-low, 2'b10 for wait-until-high, 2'b11 for sleep and 2'b00 for no operation. A wait ends only when the event line chosen by `cmd_evt_sel_i` reaches the requested level. Activity on the other event lines has no effect.
- R3: A wait whose condition already holds on the synchronized line pulses `resume_o` at the next rising edge, and `clk_en_o` stays high.
- R4: `clk_en_o` goes low at the rising edge after a wait or sleep command is accepted. It stays low for as long as the block waits or sleeps.
- R5: `resume_o` is a single-cycle pulse. `clk_en_o` is already high in the cycle before it.
- R6: A sleep with a nonzero `cmd_wake_mask_i` (bit i arms wake source i) ends when an armed wake source goes high. Unarmed wake sources have no effect.
- R7: A sleep command with an all-zero mask is ignored. `sleep_err_o` pulses for one cycle at the next rising edge, and `clk_en_o` stays high.
- R8: On a resume after reset or wake-up, `vec_valid_o` is high together with `resume_o`, and `vec_addr_o` equals `vec_base_i` plus an index. The index is 0 for reset and i+1 for wake source i, and the lowest-numbered armed source that is high wins. A resume that ends a wait leaves `vec_valid_o` low.
- R9: After reset, `clk_en_o` stays low until `core_ready_i` is seen high. A reset resume with index 0 then follows, with the R5 ordering.
- R10: Commands are accepted only while idle. A command presented during a wait or sleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Asynchronous event lines |
| wake_i | input | 4 | Asynchronous wake sources |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code |
| cmd_evt_sel_i | input | 3 | Event line chosen by a wait |
| cmd_wake_mask_i | input | 4 | Wake sources armed by a sleep |
| vec_base_i | input | 16 | Vector table base address |
| core_ready_i | input | 1 | Core ready for its reset vector |
| clk_en_o | output | 1 | Core clock enable |
| resume_o | output | 1 | Resume strobe |
| vec_valid_o | output | 1 | Resume goes through the vector table |
| vec_addr_o | output | 16 | Handler address |
| sleep_err_o | output | 1 | Sleep with no armed source was rejected |

## Verification
Two of the block's functions can fall in the same cycle.

The first pair is arbitration between wake sources. The bench raises several armed sources at once, often together with unarmed ones, and checks the vector index against the lowest armed bit, which it computes itself.

The second pair is a new command against a wait in progress. The bench issues a sleep command while a wait is pending, then checks that the wait still ends with no vector. The bench also toggles the unselected event lines on every cycle of a wait, and checks that the clock enable stays low until exactly the third edge after the chosen line changes.

// File: rtl/evt_wake_pkg.sv
package evt_wake_pkg;

  localparam int VEC_W = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WAIT0 = 2'b01,
    OP_WAIT1 = 2'b10,
    OP_SLEEP = 2'b11
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WAIT,
    ST_SLEEP,
    ST_RELEASE,
    ST_RESUME
  } ctl_state_e;

  // handler address: table base plus entry index
  function automatic logic [VEC_W-1:0] vec_target(input logic [VEC_W-1:0] base,
                                                  input int unsigned idx);
    return base + VEC_W'(idx);
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
  parameter int NUM_WAKE = 4,
  localparam int IDX_W   = $clog2(NUM_WAKE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] pend_i,
  output logic [NUM_WAKE-1:0] grant_o,
  output logic                any_o,
  output logic [IDX_W-1:0]    idx_o
);

  // lower_hit[i]: some source below i is pending
  logic [NUM_WAKE:0] lower_hit;
  assign lower_hit[0] = 1'b0;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_prio
    assign grant_o[i]     = pend_i[i] & ~lower_hit[i];
    assign lower_hit[i+1] = lower_hit[i] | pend_i[i];
  end

  assign any_o = lower_hit[NUM_WAKE];

  always_comb begin
    idx_o = '0;
    for (int i = NUM_WAKE - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i + 1);
    end
  end

  assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> $countones(grant_o) == 1);
  assert_grant_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> $onehot0(grant_o) && idx_o == '0);

endmodule

// File: rtl/evt_wake_fsm.sv
module evt_wake_fsm
  import evt_wake_pkg::*;
#(
  parameter int NUM_EVT  = 8,
  parameter int NUM_WAKE = 4,
  localparam int SEL_W   = $clog2(NUM_EVT),
  localparam int IDX_W   = $clog2(NUM_WAKE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_s_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [SEL_W-1:0]    cmd_evt_sel_i,
  input  logic [NUM_WAKE-1:0] cmd_wake_mask_i,
  input  logic                core_ready_i,
  input  logic                wake_any_i,
  input  logic [IDX_W-1:0]    wake_idx_i,
  output logic [NUM_WAKE-1:0] arm_mask_o,
  output logic                clk_en_o,
  output logic                resume_o,
  output logic                use_vec_o,
  output logic [IDX_W-1:0]    vec_idx_o,
  output logic                sleep_err_o
);

  ctl_state_e          state_q, state_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic                lvl_q, lvl_d;
  logic [NUM_WAKE-1:0] mask_q, mask_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                usevec_q, usevec_d;
  logic                err_q, err_d;

  // named events for the assertions
  logic cmd_take, wait_cmd, cmd_level, wait_met, sleep_bad;

  assign cmd_take  = cmd_valid_i && (state_q == ST_IDLE);
  assign wait_cmd  = (cmd_op_i == OP_WAIT0) || (cmd_op_i == OP_WAIT1);
  assign cmd_level = (cmd_op_i == OP_WAIT1);
  assign wait_met  = (evt_s_i[sel_q] == lvl_q);
  assign sleep_bad = cmd_take && (cmd_op_i == OP_SLEEP) && (cmd_wake_mask_i == '0);

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    lvl_d    = lvl_q;
    mask_d   = mask_q;
    idx_d    = idx_q;
    usevec_d = usevec_q;
    err_d    = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        if (core_ready_i) begin
          idx_d    = '0;
          usevec_d = 1'b1;
          state_d  = ST_RELEASE;
        end
      end
      ST_IDLE: begin
        if (cmd_take && wait_cmd) begin
          sel_d    = cmd_evt_sel_i;
          lvl_d    = cmd_level;
          usevec_d = 1'b0;
          state_d  = (evt_s_i[cmd_evt_sel_i] == cmd_level) ? ST_RESUME : ST_WAIT;
        end else if (cmd_take && cmd_op_i == OP_SLEEP) begin
          if (sleep_bad) begin
            err_d = 1'b1;
          end else begin
            mask_d  = cmd_wake_mask_i;
            state_d = ST_SLEEP;
          end
        end
      end
      ST_WAIT: begin
        if (wait_met) begin
          usevec_d = 1'b0;
          state_d  = ST_RELEASE;
        end
      end
      ST_SLEEP: begin
        if (wake_any_i) begin
          idx_d    = wake_idx_i;
          usevec_d = 1'b1;
          state_d  = ST_RELEASE;
        end
      end
      ST_RELEASE: state_d = ST_RESUME;
      ST_RESUME:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_BOOT;
      sel_q    <= '0;
      lvl_q    <= 1'b0;
      mask_q   <= '0;
      idx_q    <= '0;
      usevec_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      lvl_q    <= lvl_d;
      mask_q   <= mask_d;
      idx_q    <= idx_d;
      usevec_q <= usevec_d;
      err_q    <= err_d;
    end
  end

  assign arm_mask_o  = (state_q == ST_SLEEP) ? mask_q : '0;
  assign clk_en_o    = !(state_q inside {ST_BOOT, ST_WAIT, ST_SLEEP});
  assign resume_o    = (state_q == ST_RESUME);
  assign use_vec_o   = usevec_q;
  assign vec_idx_o   = idx_q;
  assign sleep_err_o = err_q;

  assert_clk_before_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> $past(clk_en_o) && !$past(resume_o));
  assert_resume_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);
  assert_gate_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(cmd_take));
  assert_no_resume_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> !resume_o);
  assert_err_keeps_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_err_o |-> clk_en_o && !resume_o && $past(sleep_bad));
  assert_immediate_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take && wait_cmd && (evt_s_i[cmd_evt_sel_i] == cmd_level) |=> resume_o && clk_en_o);

endmodule

// File: rtl/evt_wake_ctrl.sv
module evt_wake_ctrl
  import evt_wake_pkg::*;
#(
  parameter int NUM_EVT     = 8,
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_EVT),
  localparam int IDX_W      = $clog2(NUM_WAKE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [SEL_W-1:0]    cmd_evt_sel_i,
  input  logic [NUM_WAKE-1:0] cmd_wake_mask_i,
  input  logic [VEC_W-1:0]    vec_base_i,
  input  logic                core_ready_i,
  output logic                clk_en_o,
  output logic                resume_o,
  output logic                vec_valid_o,
  output logic [VEC_W-1:0]    vec_addr_o,
  output logic                sleep_err_o
);

  logic [NUM_EVT-1:0]  evt_s;
  logic [NUM_WAKE-1:0] wake_s, arm_mask, wake_pend, wake_grant;
  logic                wake_any, use_vec;
  logic [IDX_W-1:0]    wake_idx, vec_idx;

  evt_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .async_i(evt_i), .sync_o(evt_s));

  evt_sync #(.WIDTH(NUM_WAKE), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wake_i), .sync_o(wake_s));

  assign wake_pend = wake_s & arm_mask;

  wake_arbiter #(.NUM_WAKE(NUM_WAKE)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(wake_pend),
    .grant_o(wake_grant), .any_o(wake_any), .idx_o(wake_idx));

  evt_wake_fsm #(.NUM_EVT(NUM_EVT), .NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt_s_i(evt_s),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_evt_sel_i(cmd_evt_sel_i), .cmd_wake_mask_i(cmd_wake_mask_i),
    .core_ready_i(core_ready_i), .wake_any_i(wake_any), .wake_idx_i(wake_idx),
    .arm_mask_o(arm_mask), .clk_en_o(clk_en_o), .resume_o(resume_o),
    .use_vec_o(use_vec), .vec_idx_o(vec_idx), .sleep_err_o(sleep_err_o));

  assign vec_valid_o = resume_o && use_vec;
  assign vec_addr_o  = vec_target(vec_base_i, int'(vec_idx));

  assert_vec_with_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> resume_o);
  assert_wake_only_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_grant & ~arm_mask) == '0);

endmodule

// File: tb/sim_evt_wake_ctrl.sv
module sim_evt_wake_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic [3:0]  wake_i;
  logic        cmd_valid_i;
  logic [1:0]  cmd_op_i;
  logic [2:0]  cmd_evt_sel_i;
  logic [3:0]  cmd_wake_mask_i;
  logic [15:0] vec_base_i;
  logic        core_ready_i;
  logic        clk_en_o, resume_o, vec_valid_o, sleep_err_o;
  logic [15:0] vec_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evt_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wake_i(wake_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_evt_sel_i(cmd_evt_sel_i),
    .cmd_wake_mask_i(cmd_wake_mask_i), .vec_base_i(vec_base_i),
    .core_ready_i(core_ready_i), .clk_en_o(clk_en_o), .resume_o(resume_o),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o), .sleep_err_o(sleep_err_o));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // expected handler index: 0 none, else lowest armed high source plus one
  function automatic int exp_index(input logic [3:0] lines, input logic [3:0] mask);
    logic [3:0] hit = lines & mask;
    for (int b = 0; b < 4; b++) if (hit[b]) return b + 1;
    return 0;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [2:0] sel, input logic [3:0] mask);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_evt_sel_i = sel; cmd_wake_mask_i = mask;
    step();
    cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
  endtask

  // blocked wait, released after 'hold' cycles; optional sleep poke mid-wait
  task automatic blocked_wait(input logic lvl, input logic [2:0] sel, input int hold,
                              input bit poke);
    evt_i[sel] = ~lvl;
    repeat (3) step();
    issue(lvl ? 2'b10 : 2'b01, sel, 4'h0);
    chk("R4", "clk_en after wait issue", clk_en_o, 0);
    for (int c = 0; c < hold; c++) begin
      logic [7:0] r = 8'($urandom);
      evt_i = (r & ~(8'b1 << sel)) | (evt_i & (8'b1 << sel));
      if (poke && c == 0) issue(2'b11, 3'd0, 4'hF); else step();
      chk("R2", "clk_en held during wait", clk_en_o, 0);
    end
    evt_i[sel] = lvl;
    step(); chk("R1", "clk_en edge1", clk_en_o, 0);
    step(); chk("R1", "clk_en edge2", clk_en_o, 0);
    step(); chk("R1", "clk_en edge3", clk_en_o, 1);
    chk("R5", "no resume with clk_en rise", resume_o, 0);
    step(); chk("R1", "resume edge4", resume_o, 1);
    chk("R8", "wait resume has no vector", vec_valid_o, 0);
    if (poke) chk("R10", "sleep during wait ignored", vec_valid_o, 0);
    step(); chk("R5", "resume single cycle", resume_o, 0);
    chk("R10", "idle after wait", clk_en_o, 1);
  endtask

  task automatic quick_wait(input logic lvl, input logic [2:0] sel);
    evt_i[sel] = lvl;
    repeat (3) step();
    issue(lvl ? 2'b10 : 2'b01, sel, 4'h0);
    chk("R3", "immediate resume", resume_o, 1);
    chk("R3", "clk_en kept", clk_en_o, 1);
    chk("R8", "no vector on wait", vec_valid_o, 0);
    step(); chk("R5", "resume single cycle", resume_o, 0);
  endtask

  task automatic sleep_wake(input logic [3:0] mask, input logic [3:0] lines, input int hold);
    int idx = exp_index(lines, mask);
    wake_i = 4'h0;
    repeat (3) step();
    issue(2'b11, 3'd0, mask);
    chk("R4", "clk_en low in sleep", clk_en_o, 0);
    wake_i = ~mask;
    for (int c = 0; c < hold; c++) begin
      step(); chk("R6", "unarmed wake ignored", clk_en_o, 0);
    end
    wake_i = lines;
    step(); step();
    chk("R6", "still asleep edge2", clk_en_o, 0);
    step(); chk("R6", "clk_en on wake", clk_en_o, 1);
    step(); chk("R6", "resume on wake", resume_o, 1);
    chk("R8", "vector valid on wake", vec_valid_o, 1);
    chk("R8", "wake handler address", vec_addr_o, 32'(vec_base_i + 16'(idx)));
    step(); chk("R5", "resume single cycle", resume_o, 0);
    wake_i = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; evt_i = 8'h00; wake_i = 4'h0; cmd_valid_i = 1'b0;
    cmd_op_i = 2'b00; cmd_evt_sel_i = 3'd0; cmd_wake_mask_i = 4'h0;
    vec_base_i = 16'h0F40; core_ready_i = 1'b0;
    repeat (3) step();
    chk("R9", "clk_en in reset", clk_en_o, 0);
    chk("R9", "resume in reset", resume_o, 0);
    rst_n = 1'b1;
    repeat (4) begin step(); chk("R9", "held before ready", clk_en_o, 0); end
    core_ready_i = 1'b1;
    step(); chk("R9", "clk_en after ready", clk_en_o, 1);
    chk("R5", "no resume yet", resume_o, 0);
    step(); chk("R9", "reset resume", resume_o, 1);
    chk("R8", "reset vector valid", vec_valid_o, 1);
    chk("R8", "reset vector address", vec_addr_o, 32'h0F40);
    step(); chk("R5", "reset resume single", resume_o, 0);

    // directed corners
    quick_wait(1'b1, 3'd5);
    quick_wait(1'b0, 3'd2);
    blocked_wait(1'b1, 3'd7, 4, 1'b1);
    blocked_wait(1'b0, 3'd0, 2, 1'b0);
    issue(2'b11, 3'd0, 4'h0);
    chk("R7", "sleep error strobe", sleep_err_o, 1);
    chk("R7", "clk_en kept", clk_en_o, 1);
    step(); chk("R7", "error single cycle", sleep_err_o, 0);
    chk("R7", "still running", clk_en_o, 1);
    sleep_wake(4'b1010, 4'b1111, 3);
    sleep_wake(4'b1000, 4'b1000, 1);
    sleep_wake(4'b0001, 4'b0001, 0);

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      int kind = int'($urandom_range(0, 2));
      vec_base_i = 16'($urandom) & 16'hFFF0;
      if (kind == 0) begin
        quick_wait(1'($urandom), 3'($urandom));
      end else if (kind == 1) begin
        blocked_wait(1'($urandom), 3'($urandom), int'($urandom_range(0, 6)), 1'($urandom));
      end else begin
        logic [3:0] m = 4'($urandom_range(1, 15));
        logic [3:0] l = 4'($urandom) | (m & (~m + 4'd1));
        sleep_wake(m, l, int'($urandom_range(0, 4)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule